// File: doc/BRIEF.md
# Interrupt Context Save and Restore Unit

This unit sequences interrupt entry and exit for a small 8-bit processor core. It watches two kinds of source: a timer whose count wraps from its all-ones value to zero, and a set of latched external pending flags, each with its own enable. When global acceptance is on and a source fires, the unit acknowledges in that same cycle. It forces the next program address to the vector at 0 and stores the current program counter in a one-entry interrupt stack. This stack is separate from the subroutine stack. The unit also copies W, STATUS and FSR into shadow registers and hands the core a STATUS value with its page-select field cleared.

The core reports the two return-from-interrupt instructions as decode strobes. On a return, the unit drives the saved program counter as the next address and presents the shadowed W, STATUS and FSR for the core to write back. It then turns global acceptance on again. The add-to-timer variant also raises a timer add request that carries the W value current at that instruction. No source has priority over another.

A trigger that arrives while the handler runs is dropped, not deferred. The pending flags themselves keep latching outside this unit. Every output is a single-cycle strobe that the core always takes, so there is no valid/ready handshake and no back-pressure. The core must act on each strobe in the cycle it is shown.

Top module: `irq_ctx_unit`

## Requirements
- R1: After reset, `gie` is 1 and `irq_ack`, `pc_ovr_valid`, `status_wr`, `ctx_restore` and `tmr_add_valid` are all 0.
- R2: While `gie` is 1, any cycle in which OR over i of (`ext_pend[i]` AND `ext_en[i]`) rises from 0 to 1 raises `irq_ack` in that same cycle. In that cycle `pc_ovr_valid` is 1 and `pc_ovr` is 0. Every bit position works alike, so no source has priority.
- R3: While `gie` and `tmr_int_en` are 1, a cycle in which `tmr_count` is 0x00 and the previous cycle's `tmr_count` was 0xFF raises `irq_ack`. Any other pair of consecutive values does not.
- R4: In the acknowledge cycle `status_wr` is 1 and `status_wr_val` equals `cur_status` with bits 7:5 (page select) cleared. `gie` is 0 from the next cycle on.
- R5: While `gie` is 0, no trigger raises `irq_ack`. A trigger seen during the handler is discarded, and a pending level still high after the return does not fire.
- R6: A return strobe while `gie` is 0 raises `ctx_restore` and `pc_ovr_valid` in that cycle. `pc_ovr` carries the `cur_pc` of the acknowledge cycle, and `rest_w`, `rest_status` and `rest_fsr` carry the `cur_w`, the unmodified `cur_status` and the `cur_fsr` of that cycle. `gie` is 1 from the next cycle on.
- R7: A return through `ret_addw` also raises `tmr_add_valid`, with `tmr_add_val` equal to `cur_w` in that cycle. A return through `ret_plain` alone leaves `tmr_add_valid` at 0.
- R8: A return strobe while `gie` is 1 has no effect: no `ctx_restore`, no `pc_ovr_valid`, and no `tmr_add_valid`.
- R9: A pending bit whose enable is 0 never triggers. A timer wrap with `tmr_int_en` at 0 never triggers.
- R10: When `ret_plain` and `ret_addw` are asserted together, the unit acts as the add-to-timer return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cur_pc | input | PC_W | Program counter of the instruction about to be replaced |
| cur_w | input | 8 | Current working register |
| cur_status | input | 8 | Current STATUS register, page select in bits 7:5 |
| cur_fsr | input | 8 | Current file-select register |
| ext_pend | input | N_EXT | Latched external pending flags |
| ext_en | input | N_EXT | Per-flag enables |
| tmr_int_en | input | 1 | Timer wrap interrupt enable |
| tmr_count | input | TMR_W | Current timer count |
| ret_plain | input | 1 | Decode strobe: plain return from interrupt |
| ret_addw | input | 1 | Decode strobe: return that adds W to the timer |
| irq_ack | output | 1 | Interrupt accepted this cycle |
| gie | output | 1 | Global interrupt acceptance |
| pc_ovr_valid | output | 1 | Next-PC override active |
| pc_ovr | output | PC_W | Override address (vector or saved PC) |
| status_wr | output | 1 | Write `status_wr_val` to STATUS |
| status_wr_val | output | 8 | STATUS with page select cleared |
| ctx_restore | output | 1 | Write restored W, STATUS and FSR |
| rest_w | output | 8 | Shadowed W |
| rest_status | output | 8 | Shadowed STATUS |
| rest_fsr | output | 8 | Shadowed FSR |
| tmr_add_valid | output | 1 | Add `tmr_add_val` to the timer |
| tmr_add_val | output | 8 | Value to add to the timer |

## Verification
The hardest case to reach is a fresh trigger inside the handler. The pending OR has to fall and rise again while `gie` is 0, and the level then has to stay high across the return so that a deferred or level-sensitive design would fire. For each of the eight pending bits, the bench clears the pending word for one cycle inside the handler and raises the next bit. It holds that bit through the return and then checks that no acknowledge follows. For the timer, the bench sweeps the count through every value to the wrap point and checks that only the 0xFF-to-0x00 step triggers.

// File: rtl/irq_ctx_pkg.sv
package irq_ctx_pkg;
  localparam int REG_W = 8;

  typedef struct packed {
    logic [REG_W-1:0] w;
    logic [REG_W-1:0] status;
    logic [REG_W-1:0] fsr;
  } ctx_t;

  function automatic logic [REG_W-1:0] field_mask(input int lsb, input int n);
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < REG_W; i++)
      if (i >= lsb && i < lsb + n) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/irq_src_detect.sv
module irq_src_detect #(
  parameter int N_EXT = 8,
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EXT-1:0] ext_pend,
  input  logic [N_EXT-1:0] ext_en,
  input  logic             tmr_int_en,
  input  logic [TMR_W-1:0] tmr_count,
  output logic             ext_trig,
  output logic             tmr_trig
);
  logic [N_EXT-1:0] live;
  logic             ext_any, ext_any_q;
  logic [TMR_W-1:0] tmr_prev;

  for (genvar g = 0; g < N_EXT; g++) begin : g_mask
    assign live[g] = ext_pend[g] & ext_en[g];
  end

  assign ext_any = |live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_any_q <= 1'b0;
      tmr_prev  <= '0;
    end else begin
      ext_any_q <= ext_any;
      tmr_prev  <= tmr_count;
    end
  end

  assign ext_trig = ext_any & ~ext_any_q;
  assign tmr_trig = tmr_int_en & (&tmr_prev) & ~(|tmr_count);
endmodule

// File: rtl/irq_ctx_stack.sv
module irq_ctx_stack
  import irq_ctx_pkg::*;
#(
  parameter int PC_W = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [PC_W-1:0] pc_in,
  input  ctx_t            ctx_in,
  output logic [PC_W-1:0] pc_top,
  output ctx_t            ctx_top
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_top  <= '0;
      ctx_top <= '0;
    end else if (push) begin
      pc_top  <= pc_in;
      ctx_top <= ctx_in;
    end
  end
endmodule

// File: rtl/irq_seq.sv
module irq_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  input  logic ret_plain,
  input  logic ret_addw,
  output logic gie,
  output logic ack,
  output logic restore,
  output logic add_req
);
  assign ack     = gie & trig;
  assign restore = ~gie & (ret_plain | ret_addw);
  assign add_req = ~gie & ret_addw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gie <= 1'b1;
    else if (ack)     gie <= 1'b0;
    else if (restore) gie <= 1'b1;
  end
endmodule

// File: rtl/irq_ctx_unit.sv
module irq_ctx_unit
  import irq_ctx_pkg::*;
#(
  parameter int PC_W     = 11,
  parameter int N_EXT    = 8,
  parameter int TMR_W    = 8,
  parameter int PAGE_LSB = 5,
  parameter int PAGE_N   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PC_W-1:0]  cur_pc,
  input  logic [7:0]       cur_w,
  input  logic [7:0]       cur_status,
  input  logic [7:0]       cur_fsr,
  input  logic [N_EXT-1:0] ext_pend,
  input  logic [N_EXT-1:0] ext_en,
  input  logic             tmr_int_en,
  input  logic [TMR_W-1:0] tmr_count,
  input  logic             ret_plain,
  input  logic             ret_addw,
  output logic             irq_ack,
  output logic             gie,
  output logic             pc_ovr_valid,
  output logic [PC_W-1:0]  pc_ovr,
  output logic             status_wr,
  output logic [7:0]       status_wr_val,
  output logic             ctx_restore,
  output logic [7:0]       rest_w,
  output logic [7:0]       rest_status,
  output logic [7:0]       rest_fsr,
  output logic             tmr_add_valid,
  output logic [7:0]       tmr_add_val
);
  localparam logic [REG_W-1:0] PAGE_MASK = field_mask(PAGE_LSB, PAGE_N);
  localparam logic [PC_W-1:0]  VECTOR    = '0;

  logic ext_trig, tmr_trig, add_req;
  logic [PC_W-1:0] saved_pc;
  ctx_t cur_ctx, saved_ctx;

  irq_src_detect #(.N_EXT(N_EXT), .TMR_W(TMR_W)) u_src (
    .clk(clk), .rst_n(rst_n), .ext_pend(ext_pend), .ext_en(ext_en),
    .tmr_int_en(tmr_int_en), .tmr_count(tmr_count),
    .ext_trig(ext_trig), .tmr_trig(tmr_trig)
  );

  irq_seq u_seq (
    .clk(clk), .rst_n(rst_n), .trig(ext_trig | tmr_trig),
    .ret_plain(ret_plain), .ret_addw(ret_addw),
    .gie(gie), .ack(irq_ack), .restore(ctx_restore), .add_req(add_req)
  );

  assign cur_ctx = '{w: cur_w, status: cur_status, fsr: cur_fsr};

  irq_ctx_stack #(.PC_W(PC_W)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(irq_ack), .pc_in(cur_pc),
    .ctx_in(cur_ctx), .pc_top(saved_pc), .ctx_top(saved_ctx)
  );

  always_comb begin
    pc_ovr_valid = irq_ack | ctx_restore;
    pc_ovr       = irq_ack ? VECTOR : (ctx_restore ? saved_pc : '0);
  end

  assign status_wr     = irq_ack;
  assign status_wr_val = cur_status & ~PAGE_MASK;
  assign rest_w        = saved_ctx.w;
  assign rest_status   = saved_ctx.status;
  assign rest_fsr      = saved_ctx.fsr;
  assign tmr_add_valid = add_req;
  assign tmr_add_val   = cur_w;
endmodule

// File: rtl/irq_ctx_chk.sv
module irq_ctx_chk #(
  parameter int PC_W = 11
) (
  input logic            clk,
  input logic            rst_n,
  input logic            irq_ack,
  input logic            gie,
  input logic            pc_ovr_valid,
  input logic [PC_W-1:0] pc_ovr,
  input logic            status_wr,
  input logic [7:0]      status_wr_val,
  input logic            ctx_restore,
  input logic            tmr_add_valid
);
  a_r4_gie_drops: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !gie);
  a_r6_gie_back: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_restore |=> gie);
  a_r5_no_nest: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> !irq_ack);
  a_r2_vector: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> (pc_ovr_valid && pc_ovr == '0));
  a_r4_page_clear: assert property (@(posedge clk) disable iff (!rst_n)
    status_wr |-> (status_wr_val[7:5] == 3'b000));
  a_r7_add_with_return: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_add_valid |-> ctx_restore);
  a_r8_no_idle_return: assert property (@(posedge clk) disable iff (!rst_n)
    gie |-> !ctx_restore);
endmodule

bind irq_ctx_unit irq_ctx_chk #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_ack(irq_ack), .gie(gie),
  .pc_ovr_valid(pc_ovr_valid), .pc_ovr(pc_ovr), .status_wr(status_wr),
  .status_wr_val(status_wr_val), .ctx_restore(ctx_restore),
  .tmr_add_valid(tmr_add_valid)
);

// File: tb/irq_ctx_unit_test.sv
module irq_ctx_unit_test;
  localparam int PC_W = 11;
  localparam int N_EXT = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PC_W-1:0] cur_pc = '0;
  logic [7:0] cur_w = '0, cur_status = '0, cur_fsr = '0;
  logic [N_EXT-1:0] ext_pend = '0, ext_en = '0;
  logic tmr_int_en = 1'b0;
  logic [7:0] tmr_count = '0;
  logic ret_plain = 1'b0, ret_addw = 1'b0;
  logic irq_ack, gie, pc_ovr_valid, status_wr, ctx_restore, tmr_add_valid;
  logic [PC_W-1:0] pc_ovr;
  logic [7:0] status_wr_val, rest_w, rest_status, rest_fsr, tmr_add_val;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_ctx_unit uut (
    .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .cur_w(cur_w),
    .cur_status(cur_status), .cur_fsr(cur_fsr), .ext_pend(ext_pend),
    .ext_en(ext_en), .tmr_int_en(tmr_int_en), .tmr_count(tmr_count),
    .ret_plain(ret_plain), .ret_addw(ret_addw), .irq_ack(irq_ack), .gie(gie),
    .pc_ovr_valid(pc_ovr_valid), .pc_ovr(pc_ovr), .status_wr(status_wr),
    .status_wr_val(status_wr_val), .ctx_restore(ctx_restore),
    .rest_w(rest_w), .rest_status(rest_status), .rest_fsr(rest_fsr),
    .tmr_add_valid(tmr_add_valid), .tmr_add_val(tmr_add_val)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    settle();
    check("R1 gie", gie, 1);
    check("R1 ack", irq_ack, 0);
    check("R1 pc_ovr_valid", pc_ovr_valid, 0);
    check("R1 status_wr", status_wr, 0);
    check("R1 restore", ctx_restore, 0);
    check("R1 add", tmr_add_valid, 0);
    tick();

    ext_en = '1;
    for (int i = 0; i < N_EXT; i++) begin
      logic [PC_W-1:0] pcv;
      logic [7:0] wv, stv, fv;
      int j;
      bit addw;
      pcv = PC_W'(i * 101 + 7);
      wv  = 8'(i * 37 + 5);
      stv = 8'hFF ^ 8'(i << 1);
      fv  = 8'(i * 19 + 3);
      j = (i + 1) % N_EXT;
      addw = (i % 2 == 1) || (i == 6);
      cur_pc = pcv; cur_w = wv; cur_status = stv; cur_fsr = fv;
      ext_pend = N_EXT'(1) << i;
      settle();
      check("R2 ack", irq_ack, 1);
      check("R2 pc_ovr_valid", pc_ovr_valid, 1);
      check("R2 vector", pc_ovr, 0);
      check("R4 status_wr", status_wr, 1);
      check("R4 page cleared", status_wr_val, stv & 8'h1F);
      tick();
      cur_pc = ~pcv; cur_w = ~wv; cur_status = 8'h00; cur_fsr = ~fv;
      settle();
      check("R4 gie low", gie, 0);
      check("R5 level held", irq_ack, 0);
      tick();
      ext_pend = '0;
      tick();
      ext_pend = N_EXT'(1) << j;
      settle();
      check("R5 new trigger dropped", irq_ack, 0);
      tick();
      if (i == 6) begin
        ret_plain = 1'b1; ret_addw = 1'b1;   // R10 both strobes
      end else if (addw) ret_addw = 1'b1;
      else ret_plain = 1'b1;
      settle();
      check("R6 restore", ctx_restore, 1);
      check("R6 pc_ovr_valid", pc_ovr_valid, 1);
      check("R6 pc", pc_ovr, pcv);
      check("R6 w", rest_w, wv);
      check("R6 status", rest_status, stv);
      check("R6 fsr", rest_fsr, fv);
      check(i == 6 ? "R10 add" : "R7 add", tmr_add_valid, addw);
      if (addw) check("R7 add value", tmr_add_val, 8'(~wv));
      tick();
      ret_plain = 1'b0; ret_addw = 1'b0;
      settle();
      check("R6 gie back", gie, 1);
      check("R5 no late fire", irq_ack, 0);
      tick();
      ext_pend = '0;
      tick();
    end

    ret_plain = 1'b1;
    settle();
    check("R8 no restore", ctx_restore, 0);
    check("R8 no override", pc_ovr_valid, 0);
    tick();
    ret_plain = 1'b0;
    ret_addw = 1'b1;
    settle();
    check("R8 no add", tmr_add_valid, 0);
    tick();
    ret_addw = 1'b0;

    ext_en = '0;
    ext_pend = '1;
    settle();
    check("R9 masked pend", irq_ack, 0);
    tick();
    ext_pend = '0;
    tick();

    tmr_int_en = 1'b1;
    tmr_count = 8'h00;
    tick();
    for (int c = 1; c <= 256; c++) begin
      tmr_count = 8'(c);
      settle();
      if (c == 256 || irq_ack) check("R3 wrap only", irq_ack, (c == 256) ? 1 : 0);
      tick();
    end
    ret_plain = 1'b1;
    tick();
    ret_plain = 1'b0;
    tmr_count = 8'hFE;
    tick();
    tmr_count = 8'h00;
    settle();
    check("R3 no wrap from FE", irq_ack, 0);
    tick();
    tmr_int_en = 1'b0;
    tmr_count = 8'hFF;
    tick();
    tmr_count = 8'h00;
    settle();
    check("R9 timer disabled", irq_ack, 0);
    tick();
    finish_run();
  end
endmodule